// File: doc/BRIEF.md
# Frame-Locked Tick Counter with System Control Port

This block makes a periodic tick, six per video frame, from two strobes sent by the video timing logic. One strobe marks the start of each frame and the other marks each scan line. It counts the ticks that have not been acknowledged in a 4-bit counter that stops at fifteen. Any non-zero count holds the CPU maskable interrupt high. The floppy controller interrupt can be sent to the maskable interrupt, to the non-maskable interrupt, or to neither.

The CPU sees two I/O ports. At 0xF8, a read returns flyback, floppy interrupt, screen height and tick count, and a write takes a command code that drives the system control outputs. At 0xF4, a read returns the same status byte and also acknowledges the ticks by clearing the count.

The flyback status bit stays high for the whole frame flyback. On every other scan line it goes high only briefly. Software can therefore tell frame flyback from line flyback by reading the bit twice in a row.

Top module: `frame_tick_ctl`

## Requirements
- R1: After reset the tick count is 0, cpu_int and cpu_nmi are low, the floppy interrupt goes to neither CPU input, fdc_tc, ext_video_en, motor_en, beep_en and sys_reset_req are low, and boot_mode is high.
- R2: The tick sequencer is in one of four states: SEQ_IDLE, SEQ_LEAD, SEQ_SPACE or SEQ_DONE. A frame strobe always takes it to SEQ_LEAD and restarts the line count. In SEQ_LEAD the 2nd line strobe after the frame strobe gives a tick and moves to SEQ_SPACE. In SEQ_SPACE every 52nd line strobe gives a tick, and the 6th tick of the frame moves to SEQ_DONE. SEQ_IDLE, the state after reset, and SEQ_DONE ignore line strobes.
- R3: Each tick adds one to the tick count. At 15 the count saturates and does not wrap.
- R4: During any cycle with io_rd high and io_addr = 0xF8, io_rdata reads combinationally as follows: bit 7 = 0, bit 6 = flyback, bit 5 = fdc_irq as sampled, bit 4 = tall_screen, bits 3..0 = tick count. This read clears nothing.
- R5: A read at 0xF4 returns the same byte as a read at 0xF8 and clears the count at the end of that cycle. If a tick falls in that same cycle, the count becomes 1.
- R6: A read at any other address returns 0 and leaves the count unchanged.
- R7: Writing 2, 3 or 4 to 0xF8 sends the floppy interrupt to cpu_nmi, to cpu_int, or to neither.
- R8: cpu_int is high while the count is non-zero, or while the floppy interrupt is routed to it and fdc_irq is high. cpu_nmi is high only while the floppy interrupt is routed to it and fdc_irq is high.
- R9: Writing 5/6 to 0xF8 sets/clears fdc_tc, 7/8 sets/clears ext_video_en, 9/10 sets/clears motor_en, and 11/12 sets/clears beep_en. Each output is registered and changes in the cycle after the write.
- R10: Writing 0 to 0xF8 clears boot_mode, which then stays low until reset. Writing 1 gives a sys_reset_req pulse exactly one cycle long.
- R11: A write of 13 to 255 to 0xF8, and any write to another address, changes no output.
- R12: The flyback bit goes high in the cycle after a frame strobe. It stays high until the 16th line strobe after that frame strobe. Apart from that, it is high for the 4 cycles that follow each line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse at each scan line start |
| frame_strobe | input | 1 | One-cycle pulse at frame flyback start |
| fdc_irq | input | 1 | Floppy controller interrupt request |
| tall_screen | input | 1 | Screen-height flag reported in status bit 4 |
| io_rd | input | 1 | I/O read cycle |
| io_wr | input | 1 | I/O write cycle |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Status byte during reads of 0xF4/0xF8, else 0 |
| cpu_int | output | 1 | Maskable interrupt request |
| cpu_nmi | output | 1 | Non-maskable interrupt request |
| beep_en | output | 1 | Beeper enable |
| motor_en | output | 1 | Disk motor enable |
| fdc_tc | output | 1 | Floppy terminal count |
| ext_video_en | output | 1 | External video enable |
| boot_mode | output | 1 | High until the end-boot command |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench runs whole frames and counts line strobes. A sequencer that is off by one in the lead-in or the spacing puts the first or the second tick on the wrong line. One that does not stop after six ticks lets the count go past six. Further frames push the count over fifteen; a counter that wraps would read a small value instead of 15. One acknowledging read is placed in the same cycle as a tick: a design that lets the clear win loses that tick and reads 0 instead of 1. The flyback bit is sampled late in the 15th and the 16th flyback lines and just after an ordinary line strobe, which catches frame flyback held one line too long or too short. Unknown command codes and writes to the other port must leave every control output alone.

// File: rtl/frame_tick_pkg.sv
package frame_tick_pkg;

    typedef enum logic [1:0] {
        FDC_ROUTE_NONE,
        FDC_ROUTE_NMI,
        FDC_ROUTE_INT
    } fdc_route_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SPACE,
        SEQ_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_END_BOOT  = 8'd0;
    localparam logic [7:0] CMD_RESET     = 8'd1;
    localparam logic [7:0] CMD_FDC_NMI   = 8'd2;
    localparam logic [7:0] CMD_FDC_INT   = 8'd3;
    localparam logic [7:0] CMD_FDC_NONE  = 8'd4;
    localparam logic [7:0] CMD_TC_ON     = 8'd5;
    localparam logic [7:0] CMD_TC_OFF    = 8'd6;
    localparam logic [7:0] CMD_VID_ON    = 8'd7;
    localparam logic [7:0] CMD_VID_OFF   = 8'd8;
    localparam logic [7:0] CMD_MOTOR_ON  = 8'd9;
    localparam logic [7:0] CMD_MOTOR_OFF = 8'd10;
    localparam logic [7:0] CMD_BEEP_ON   = 8'd11;
    localparam logic [7:0] CMD_BEEP_OFF  = 8'd12;

endpackage

// File: rtl/tick_sequencer.sv
module tick_sequencer
    import frame_tick_pkg::*;
#(
    parameter int FIRST_LINE    = 2,
    parameter int SPACING_LINES = 52,
    parameter int TICKS         = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    input  logic line_strobe,
    output logic tick
);
    localparam int MAXL = (FIRST_LINE > SPACING_LINES) ? FIRST_LINE : SPACING_LINES;
    localparam int LW   = $clog2(MAXL + 1);
    localparam int TW   = $clog2(TICKS + 1);
    localparam logic [LW-1:0] FIRST_M1 = LW'(FIRST_LINE - 1);
    localparam logic [LW-1:0] SPACE_M1 = LW'(SPACING_LINES - 1);
    localparam logic [TW-1:0] TICKS_M1 = TW'(TICKS - 1);

    seq_state_e      state_q, state_d;
    logic [LW-1:0]   line_q, line_d;
    logic [TW-1:0]   num_q, num_d;
    logic            lead_hit, space_hit;

    assign lead_hit  = line_strobe && (line_q == FIRST_M1);
    assign space_hit = line_strobe && (line_q == SPACE_M1);

    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        num_d   = num_q;
        if (frame_strobe) begin
            state_d = SEQ_LEAD;
            line_d  = '0;
            num_d   = '0;
        end else if (line_strobe) begin
            unique case (state_q)
                SEQ_IDLE, SEQ_DONE: ;
                SEQ_LEAD: begin
                    if (lead_hit) begin
                        line_d  = '0;
                        num_d   = TW'(1);
                        state_d = (TICKS == 1) ? SEQ_DONE : SEQ_SPACE;
                    end else begin
                        line_d = line_q + 1'b1;
                    end
                end
                SEQ_SPACE: begin
                    if (space_hit) begin
                        line_d = '0;
                        num_d  = num_q + 1'b1;
                        if (num_q + 1'b1 == TICKS_M1 + 1'b1) state_d = SEQ_DONE;
                    end else begin
                        line_d = line_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            line_q  <= '0;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            num_q   <= num_d;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (!frame_strobe) begin
            unique case (state_q)
                SEQ_IDLE, SEQ_DONE: tick = 1'b0;
                SEQ_LEAD:           tick = lead_hit;
                SEQ_SPACE:          tick = space_hit;
            endcase
        end
    end

endmodule

// File: rtl/flyback_gen.sv
module flyback_gen #(
    parameter int FLY_LINES    = 16,
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    input  logic line_strobe,
    output logic flyback
);
    localparam int FW = $clog2(FLY_LINES + 1);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [FW-1:0] FLY_M1 = FW'(FLY_LINES - 1);

    logic          frame_fly_q;
    logic [FW-1:0] fly_lines_q;
    logic [PW-1:0] pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_fly_q <= 1'b0;
            fly_lines_q <= '0;
        end else if (frame_strobe) begin
            frame_fly_q <= 1'b1;
            fly_lines_q <= '0;
        end else if (line_strobe && frame_fly_q) begin
            if (fly_lines_q == FLY_M1) frame_fly_q <= 1'b0;
            else                       fly_lines_q <= fly_lines_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                pulse_q <= '0;
        else if (line_strobe)      pulse_q <= PW'(PULSE_CYCLES);
        else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end

    assign flyback = frame_fly_q || (pulse_q != '0);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                         count <= '0;
        else if (clear)                     count <= tick ? CNT_W'(1) : '0;
        else if (tick && count != CNT_MAX)  count <= count + 1'b1;
    end

endmodule

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
    import frame_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd,
    output fdc_route_e route,
    output logic       tc,
    output logic       video,
    output logic       motor,
    output logic       beep,
    output logic       boot,
    output logic       reset_req
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route     <= FDC_ROUTE_NONE;
            tc        <= 1'b0;
            video     <= 1'b0;
            motor     <= 1'b0;
            beep      <= 1'b0;
            boot      <= 1'b1;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (cmd_wr) begin
                case (cmd)
                    CMD_END_BOOT:  boot      <= 1'b0;
                    CMD_RESET:     reset_req <= 1'b1;
                    CMD_FDC_NMI:   route     <= FDC_ROUTE_NMI;
                    CMD_FDC_INT:   route     <= FDC_ROUTE_INT;
                    CMD_FDC_NONE:  route     <= FDC_ROUTE_NONE;
                    CMD_TC_ON:     tc        <= 1'b1;
                    CMD_TC_OFF:    tc        <= 1'b0;
                    CMD_VID_ON:    video     <= 1'b1;
                    CMD_VID_OFF:   video     <= 1'b0;
                    CMD_MOTOR_ON:  motor     <= 1'b1;
                    CMD_MOTOR_OFF: motor     <= 1'b0;
                    CMD_BEEP_ON:   beep      <= 1'b1;
                    CMD_BEEP_OFF:  beep      <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/frame_tick_ctl.sv
module frame_tick_ctl
    import frame_tick_pkg::*;
#(
    parameter int         FIRST_LINE    = 2,
    parameter int         SPACING_LINES = 52,
    parameter int         TICKS         = 6,
    parameter int         FLY_LINES     = 16,
    parameter int         PULSE_CYCLES  = 4,
    parameter logic [7:0] STATUS_PORT   = 8'hF8,
    parameter logic [7:0] ACK_PORT      = 8'hF4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_strobe,
    input  logic       frame_strobe,
    input  logic       fdc_irq,
    input  logic       tall_screen,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       cpu_int,
    output logic       cpu_nmi,
    output logic       beep_en,
    output logic       motor_en,
    output logic       fdc_tc,
    output logic       ext_video_en,
    output logic       boot_mode,
    output logic       sys_reset_req
);
    localparam int CNT_W = 4;

    logic             seq_tick;
    logic             flyback;
    logic             rd_status, rd_ack, wr_cmd;
    logic [CNT_W-1:0] tick_cnt;
    logic [7:0]       status;
    fdc_route_e       route;

    assign rd_status = io_rd && (io_addr == STATUS_PORT);
    assign rd_ack    = io_rd && (io_addr == ACK_PORT);
    assign wr_cmd    = io_wr && (io_addr == STATUS_PORT);

    tick_sequencer #(
        .FIRST_LINE    (FIRST_LINE),
        .SPACING_LINES (SPACING_LINES),
        .TICKS         (TICKS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .line_strobe  (line_strobe),
        .tick         (seq_tick)
    );

    flyback_gen #(
        .FLY_LINES    (FLY_LINES),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_fly (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .line_strobe  (line_strobe),
        .flyback      (flyback)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (seq_tick),
        .clear (rd_ack),
        .count (tick_cnt)
    );

    ctl_cmd_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (wr_cmd),
        .cmd       (io_wdata),
        .route     (route),
        .tc        (fdc_tc),
        .video     (ext_video_en),
        .motor     (motor_en),
        .beep      (beep_en),
        .boot      (boot_mode),
        .reset_req (sys_reset_req)
    );

    assign status   = {1'b0, flyback, fdc_irq, tall_screen, tick_cnt};
    assign io_rdata = (rd_status || rd_ack) ? status : 8'h00;
    assign cpu_int  = (tick_cnt != '0) || (fdc_irq && route == FDC_ROUTE_INT);
    assign cpu_nmi  = fdc_irq && (route == FDC_ROUTE_NMI);

endmodule

// File: rtl/frame_tick_ctl_chk.sv
module frame_tick_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       ack_rd,
    input logic [3:0] tick_cnt,
    input logic       cpu_int,
    input logic       cpu_nmi,
    input logic       fdc_irq,
    input logic       boot_mode,
    input logic       sys_reset_req
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt == 4'hF && !ack_rd) |=> tick_cnt == 4'hF);

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rd |=> (tick_cnt == $past(tick_cnt)) || (tick_cnt == $past(tick_cnt) + 4'd1));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !tick) |=> tick_cnt == 4'h0);

    a_r5_ack_keeps_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && tick) |=> tick_cnt == 4'h1);

    a_r8_pending_int: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt != 4'h0) |-> cpu_int);

    a_r8_nmi_source: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_nmi |-> fdc_irq);

    a_r10_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    a_r10_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_mode |=> !boot_mode);
endmodule

bind frame_tick_ctl frame_tick_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (seq_tick),
    .ack_rd        (rd_ack),
    .tick_cnt      (tick_cnt),
    .cpu_int       (cpu_int),
    .cpu_nmi       (cpu_nmi),
    .fdc_irq       (fdc_irq),
    .boot_mode     (boot_mode),
    .sys_reset_req (sys_reset_req)
);

// File: tb/frame_tick_ctl_bench.sv
module frame_tick_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_strobe = 1'b0, frame_strobe = 1'b0;
    logic       fdc_irq = 1'b0, tall_screen = 1'b0;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cpu_int, cpu_nmi, beep_en, motor_en, fdc_tc, ext_video_en, boot_mode, sys_reset_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    frame_tick_ctl u_frame_tick_ctl (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            line_strobe = 1'b1;
            @(negedge clk);
            line_strobe = 1'b0;
            repeat (7) @(negedge clk);
        end
    endtask

    task automatic frame();
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    task automatic read_port(input logic [7:0] addr, output logic [7:0] data);
        io_rd = 1'b1;
        io_addr = addr;
        #1 data = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic write_port(input logic [7:0] addr, input logic [7:0] data);
        io_wr = 1'b1;
        io_addr = addr;
        io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic read_count(output int cnt);
        logic [7:0] d;
        read_port(8'hF8, d);
        cnt = int'(d[3:0]);
    endtask

    task automatic ctl_vector(output int v);
        v = {28'd0, fdc_tc, ext_video_en, motor_en, beep_en};
    endtask

    task automatic t_reset();
        logic [7:0] d;
        read_port(8'hF8, d);
        check("R1 status after reset", d, 8'h00);
        check("R1 cpu_int", cpu_int, 0);
        check("R1 cpu_nmi", cpu_nmi, 0);
        check("R1 controls", {fdc_tc, ext_video_en, motor_en, beep_en}, 0);
        check("R1 boot_mode", boot_mode, 1);
        check("R1 sys_reset_req", sys_reset_req, 0);
        lines(3);
        read_port(8'hF8, d);
        check("R2 idle ignores lines", d[3:0], 0);
    endtask

    task automatic t_schedule();
        int c;
        logic [7:0] d;
        frame();
        lines(1);
        read_count(c); check("R2 no tick at line 1", c, 0);
        lines(1);
        read_count(c); check("R2 tick at line 2", c, 1);
        read_count(c); check("R4 F8 read does not clear", c, 1);
        lines(51);
        read_count(c); check("R2 no tick before spacing", c, 1);
        lines(1);
        read_count(c); check("R2 second tick after 52 lines", c, 2);
        lines(4 * 52);
        read_count(c); check("R2 six ticks per frame", c, 6);
        lines(120);
        read_count(c); check("R2 done state ignores lines", c, 6);
        check("R8 int while count nonzero", cpu_int, 1);
        read_port(8'hF4, d);
        check("R5 F4 returns status", d, 8'h06);
        read_count(c); check("R5 F4 clears count", c, 0);
        check("R8 int drops after clear", cpu_int, 0);
    endtask

    task automatic t_saturate();
        int c;
        logic [7:0] d;
        for (int f = 0; f < 3; f++) begin
            frame();
            lines(263);
        end
        read_count(c); check("R3 count saturates at 15", c, 15);
        read_port(8'hF4, d);
        check("R3 saturated value read", d[3:0], 15);
    endtask

    task automatic t_tick_vs_clear();
        int c;
        logic [7:0] d;
        frame();
        lines(263);
        frame();
        lines(1);
        line_strobe = 1'b1;
        io_rd = 1'b1;
        io_addr = 8'hF4;
        #1 d = io_rdata;
        @(negedge clk);
        line_strobe = 1'b0;
        io_rd = 1'b0;
        check("R5 read shows count before clear", d[3:0], 6);
        repeat (7) @(negedge clk);
        read_count(c); check("R5 tick in clearing cycle kept", c, 1);
        read_port(8'hF4, d);
    endtask

    task automatic t_flyback();
        logic [7:0] d;
        int c;
        frame();
        read_port(8'hF8, d);
        check("R12 flyback high after frame strobe", d[6], 1);
        lines(15);
        read_port(8'hF8, d);
        check("R12 flyback held on line 15", d[6], 1);
        lines(1);
        read_port(8'hF8, d);
        check("R12 frame flyback over after line 16", d[6], 0);
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
        read_port(8'hF8, d);
        check("R12 line pulse right after strobe", d[6], 1);
        repeat (5) @(negedge clk);
        read_port(8'hF8, d);
        check("R12 line pulse ended", d[6], 0);
        read_port(8'h12, d);
        check("R6 other address reads zero", d, 0);
        read_count(c); check("R6 other read leaves count", c, 1);
        tall_screen = 1'b1;
        read_port(8'hF8, d);
        check("R4 tall screen bit 4", d, 8'h11);
        tall_screen = 1'b0;
        read_port(8'hF4, d);
    endtask

    task automatic t_route();
        logic [7:0] d;
        fdc_irq = 1'b1;
        @(negedge clk);
        check("R8 routed none int", cpu_int, 0);
        check("R8 routed none nmi", cpu_nmi, 0);
        read_port(8'hF8, d);
        check("R4 fdc bit 5", d, 8'h20);
        write_port(8'hF8, 8'd2);
        check("R7 route nmi", {cpu_nmi, cpu_int}, 2'b10);
        write_port(8'hF8, 8'd3);
        check("R7 route int", {cpu_nmi, cpu_int}, 2'b01);
        fdc_irq = 1'b0;
        #1 check("R8 int follows fdc_irq", cpu_int, 0);
        fdc_irq = 1'b1;
        write_port(8'hF8, 8'd4);
        check("R7 route none", {cpu_nmi, cpu_int}, 2'b00);
        fdc_irq = 1'b0;
    endtask

    task automatic t_controls();
        int v;
        write_port(8'hF8, 8'd5);  ctl_vector(v); check("R9 tc on", v, 4'b1000);
        write_port(8'hF8, 8'd7);  ctl_vector(v); check("R9 video on", v, 4'b1100);
        write_port(8'hF8, 8'd9);  ctl_vector(v); check("R9 motor on", v, 4'b1110);
        write_port(8'hF8, 8'd11); ctl_vector(v); check("R9 beep on", v, 4'b1111);
        write_port(8'hF8, 8'd6);  ctl_vector(v); check("R9 tc off", v, 4'b0111);
        write_port(8'hF8, 8'd8);  ctl_vector(v); check("R9 video off", v, 4'b0011);
        write_port(8'hF8, 8'd12); ctl_vector(v); check("R9 beep off", v, 4'b0010);
        write_port(8'hF8, 8'd10); ctl_vector(v); check("R9 motor off", v, 4'b0000);
    endtask

    task automatic t_ignored();
        int v;
        write_port(8'hF8, 8'd13);
        write_port(8'hF8, 8'hFF);
        write_port(8'hF4, 8'd9);
        write_port(8'hF4, 8'd0);
        write_port(8'h10, 8'd5);
        ctl_vector(v);
        check("R11 ignored writes leave controls", v, 0);
        check("R11 ignored writes leave boot", boot_mode, 1);
        check("R11 ignored writes no reset", sys_reset_req, 0);
        fdc_irq = 1'b1;
        #1 check("R11 ignored writes leave route", {cpu_nmi, cpu_int}, 2'b00);
        fdc_irq = 1'b0;
    endtask

    task automatic t_boot_reset();
        write_port(8'hF8, 8'd1);
        check("R10 reset pulse high", sys_reset_req, 1);
        @(negedge clk);
        check("R10 reset pulse one cycle", sys_reset_req, 0);
        write_port(8'hF8, 8'd0);
        check("R10 boot cleared", boot_mode, 0);
        write_port(8'hF8, 8'd11);
        write_port(8'hF8, 8'd12);
        check("R10 boot stays cleared", boot_mode, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_schedule();
        t_saturate();
        t_tick_vs_clear();
        t_flyback();
        t_route();
        t_controls();
        t_ignored();
        t_boot_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule